// File: doc/BRIEF.md
# Four-Bit Framed Sequence Detector

This block watches a serial bit stream and cuts it into back-to-back frames of four accepted bits. A bit counts only in a cycle where `in_en` is high. In every other cycle `bit_in` is ignored and the machine holds its state. When the fourth bit of a frame completes one of two target words, the block raises `hit` during that same cycle. The targets, read in arrival order, are 0,0,1,0 and 1,1,1,0. The output is Mealy style: it depends on the current state and on the bit being presented. Detection never overlaps. After every fourth accepted bit the machine is back in its start state, whether or not the frame matched. A bit that breaks both targets early does not resynchronise anything; the frame simply runs on to its end.

The machine has seven states:

- `ST_START`: no bits of the frame seen yet.
- `ST_GOT0` and `ST_GOT1`: one bit seen, holding a 0 or a 1.
- `ST_MID_OK`: two bits seen that are still on a target path, either 00 or 11.
- `ST_MID_DEAD`: two bits seen that can no longer match.
- `ST_LAST_OK`: three bits seen that are still on a target path, either 001 or 111.
- `ST_LAST_DEAD`: three bits seen that can no longer match.

Both targets share the tail 1,0, so the two prefixes 00 and 11 lead into one shared state, and so do 001 and 111. This merging is why seven states are enough.

The transitions on an accepted bit are:

| From | On 0 | On 1 |
|---|---|---|
| `ST_START` | `ST_GOT0` | `ST_GOT1` |
| `ST_GOT0` | `ST_MID_OK` | `ST_MID_DEAD` |
| `ST_GOT1` | `ST_MID_DEAD` | `ST_MID_OK` |
| `ST_MID_OK` | `ST_LAST_DEAD` | `ST_LAST_OK` |
| `ST_MID_DEAD` | `ST_LAST_DEAD` | `ST_LAST_DEAD` |
| `ST_LAST_OK` | `ST_START`, with `hit` high | `ST_START` |
| `ST_LAST_DEAD` | `ST_START` | `ST_START` |

A synchronous, active-high `rst` forces `ST_START`.

Top module: `frame_seq_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the machine goes to the start-of-frame state, and `hit` is 0 during any cycle in which `rst` is high.
- R2: The frame 0,0,1,0 (first-arriving bit first; as a 4-bit number with the first bit as MSB, value 2) raises `hit` during the cycle that presents its fourth bit.
- R3: The frame 1,1,1,0 (value 14 with the first bit as MSB) raises `hit` during the cycle that presents its fourth bit.
- R4: Each of the other fourteen 4-bit frames leaves `hit` at 0 during its fourth bit.
- R5: `hit` is 0 during the first, second and third accepted bits of every frame.
- R6: In a cycle with `in_en` low, `bit_in` is ignored, the state does not change and `hit` is 0.
- R7: After the fourth accepted bit the machine is back in the start state whatever the frame held, so consecutive frames are judged independently and stay aligned.
- R8: A reset in the middle of a frame discards the partial frame; the next accepted bit is the first bit of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to start-of-frame |
| in_en | input | 1 | High when `bit_in` carries a valid bit this cycle |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | High during the fourth bit of a matching frame |

## Verification
The bench streams every ordered pair of 4-bit frames back to back, so every frame value is seen after every other frame value. This shows that only values 2 and 14 fire, and that a match or a mismatch never bleeds into the following frame. Idle cycles with `in_en` low and a toggling `bit_in` are mixed into the stream at shifting positions, including inside frames, to show that unqualified cycles neither advance nor disturb the frame. Separate sequences reset the machine after one and after two bits of a near-matching prefix, to show that the frame restarts at the next accepted bit.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    localparam int FRAME_LEN = 4;
    localparam int POS_W     = $clog2(FRAME_LEN);

    typedef enum logic [2:0] {
        ST_START     = 3'd0,
        ST_GOT0      = 3'd1,
        ST_GOT1      = 3'd2,
        ST_MID_OK    = 3'd3,
        ST_MID_DEAD  = 3'd4,
        ST_LAST_OK   = 3'd5,
        ST_LAST_DEAD = 3'd6
    } fsd_state_e;

endpackage

// File: rtl/fsd_next.sv
module fsd_next
    import fsd_pkg::*;
(
    input  fsd_state_e cur,
    input  logic       in_en,
    input  logic       bit_in,
    output fsd_state_e nxt
);

    always_comb begin
        nxt = cur;
        if (in_en) begin
            unique case (cur)
                ST_START:     nxt = bit_in ? ST_GOT1 : ST_GOT0;
                // first bit 0: only 0 keeps the 0,0,... path alive
                ST_GOT0:      nxt = bit_in ? ST_MID_DEAD : ST_MID_OK;
                // first bit 1: only 1 keeps the 1,1,... path alive
                ST_GOT1:      nxt = bit_in ? ST_MID_OK : ST_MID_DEAD;
                // both targets need a 1 in slot three
                ST_MID_OK:    nxt = bit_in ? ST_LAST_OK : ST_LAST_DEAD;
                ST_MID_DEAD:  nxt = ST_LAST_DEAD;
                ST_LAST_OK:   nxt = ST_START;
                ST_LAST_DEAD: nxt = ST_START;
                default:      nxt = ST_START;
            endcase
        end
    end

endmodule

// File: rtl/fsd_state_reg.sv
module fsd_state_reg
    import fsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fsd_state_e nxt,
    output fsd_state_e cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= ST_START;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/fsd_out.sv
module fsd_out
    import fsd_pkg::*;
(
    input  fsd_state_e cur,
    input  logic       rst,
    input  logic       in_en,
    input  logic       bit_in,
    output logic       hit
);

    always_comb begin
        hit = 1'b0;
        if (!rst && in_en) begin
            unique case (cur)
                ST_LAST_OK: hit = ~bit_in;
                default:    hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/frame_seq_detect.sv
module frame_seq_detect
    import fsd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_en,
    input  logic bit_in,
    output logic hit
);

    fsd_state_e cur_state;
    fsd_state_e nxt_state;

    fsd_next u_next (
        .cur    (cur_state),
        .in_en  (in_en),
        .bit_in (bit_in),
        .nxt    (nxt_state)
    );

    fsd_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_state),
        .cur (cur_state)
    );

    fsd_out u_out (
        .cur    (cur_state),
        .rst    (rst),
        .in_en  (in_en),
        .bit_in (bit_in),
        .hit    (hit)
    );

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker
    import fsd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_en,
    input logic       bit_in,
    input logic       hit,
    input fsd_state_e state
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (in_en) begin
            pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
        end
    end

    always_comb begin
        if (rst) begin
            AST_NO_HIT_IN_RESET: assert (!hit); // R1
        end
    end

    AST_HIT_ON_ZERO_BIT: assert property (@(posedge clk) disable iff (rst)
        hit |-> !bit_in); // R2

    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        hit |-> in_en); // R5

    AST_HIT_LAST_SLOT: assert property (@(posedge clk) disable iff (rst)
        hit |-> (pos == LAST_POS)); // R5

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_en |=> $stable(state)); // R6

    AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
        (pos == '0) |-> (state == ST_START)); // R7

endmodule

bind frame_seq_detect fsd_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .in_en  (in_en),
    .bit_in (bit_in),
    .hit    (hit),
    .state  (cur_state)
);

// File: tb/frame_seq_detect_bench.sv
module frame_seq_detect_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_en = 1'b0;
    logic bit_in = 1'b0;
    logic hit;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frame_seq_detect u_frame_seq_detect (
        .clk    (clk),
        .rst    (rst),
        .in_en  (in_en),
        .bit_in (bit_in),
        .hit    (hit)
    );

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: hit=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic exp, input string req);
        @(negedge clk);
        rst = 1'b0;
        in_en = 1'b1;
        bit_in = b;
        #1;
        check(hit, exp, req);
    endtask

    task automatic stall(input logic junk);
        @(negedge clk);
        in_en = 1'b0;
        bit_in = junk;
        #1;
        check(hit, 1'b0, "R6 idle cycle");
    endtask

    task automatic do_reset(input logic en, input logic b);
        @(negedge clk);
        rst = 1'b1;
        in_en = en;
        bit_in = b;
        #1;
        check(hit, 1'b0, "R1 reset cycle");
    endtask

    // frame value: first bit is the MSB; only 2 and 14 match
    task automatic send_frame(input int fv, input int seed, input string tag);
        for (int k = 0; k < 4; k++) begin
            logic b;
            logic exp;
            b = fv[3 - k];
            exp = (k == 3) && (fv == 2 || fv == 14);
            if (k < 3)       send_bit(b, 1'b0, {tag, " R5 early bit"});
            else if (fv == 2)  send_bit(b, exp, {tag, " R2 frame 0010"});
            else if (fv == 14) send_bit(b, exp, {tag, " R3 frame 1110"});
            else               send_bit(b, exp, {tag, " R4 other frame"});
            if ((seed + k) % 3 == 0) stall(logic'(k[0] ^ seed[0]));
        end
    endtask

    initial begin
        // R1: reset state, with enable and a zero bit present
        do_reset(1'b1, 1'b0);
        do_reset(1'b1, 1'b1);
        // first frame right after reset matches: start state reached
        send_frame(2, 1, "R1");

        // every ordered pair of frames, streamed back to back (R7 alignment)
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                send_frame(a, a + b, "R7 first");
                send_frame(b, a * 3 + b, "R7 second");
            end
        end

        // R8: partial 1,1 then reset, then 0,0,1,0 must match
        send_bit(1'b1, 1'b0, "R8 partial");
        send_bit(1'b1, 1'b0, "R8 partial");
        do_reset(1'b1, 1'b0);
        send_bit(1'b0, 1'b0, "R8 restart");
        send_bit(1'b0, 1'b0, "R8 restart");
        send_bit(1'b1, 1'b0, "R8 restart");
        send_bit(1'b0, 1'b1, "R8 restart match");

        // R8: partial 0 then reset; 1,1,1,0 must match, not be read as offset
        send_bit(1'b0, 1'b0, "R8 partial");
        do_reset(1'b0, 1'b1);
        send_bit(1'b1, 1'b0, "R8 restart");
        send_bit(1'b1, 1'b0, "R8 restart");
        send_bit(1'b1, 1'b0, "R8 restart");
        send_bit(1'b0, 1'b1, "R8 restart match");

        // R6: long idle run with toggling data just before the last bit
        send_bit(1'b1, 1'b0, "R6 setup");
        send_bit(1'b1, 1'b0, "R6 setup");
        send_bit(1'b1, 1'b0, "R6 setup");
        for (int i = 0; i < 8; i++) stall(logic'(i[0]));
        send_bit(1'b0, 1'b1, "R6 match after idle");

        @(negedge clk);
        in_en = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule